// File: doc/BRIEF.md
# Video Command Port Decoder and CPU Memory Mapper

This block sits on the CPU I/O bus. It watches every I/O cycle for the command port of the video controller. A matching cycle carries one data byte. The top two bits of that byte pick a function and the low five bits carry its operand. From these commands the block produces:

- one-cycle strobes to the palette logic, for pen selection and for colour writes;
- the enable flags of the low and high ROM overlays;
- the video mode that will apply from the next line;
- a one-cycle pulse that clears the raster interrupt counter;
- the configuration of the 128 KB RAM banks.

For each CPU memory access the block splits the 64 KB address space into four 16 KB quarters. It reports whether a read is served by ROM, which 16 KB RAM bank backs the address, and the resulting 17-bit physical RAM address. Writes always land in RAM. The block also produces the CPU wait line, which lets the CPU run for one cycle out of every four.

The decode does not look at data direction. An input cycle to the command port also loads the byte that is on the data bus at that moment. The port also has no read path back to the CPU.

Top module: `gate_mapper`

## Requirements
- R1: A command is accepted only on a cycle with ioStrobe high and ioAddr[15:14] == 2'b01, whatever the cycle's direction. Any other address leaves every output unchanged and produces no strobe.
- R2: A byte whose bits 7:6 are 00 produces penStrobe high for exactly one cycle, in the cycle after the command. penIdx carries data bits 4:0 during that cycle.
- R3: A byte whose bits 7:6 are 01 produces inkStrobe high for exactly one cycle, in the cycle after the command. inkVal carries data bits 4:0 during that cycle.
- R4: A byte whose bits 7:6 are 10 controls the mode and the ROM overlays. nextMode takes data bits 1:0. A 1 in bit 2 clears lowerRomOn and a 0 sets it. A 1 in bit 3 clears upperRomOn and a 0 sets it.
- R5: A 10 command with data bit 4 set produces irqCountClr high for exactly one cycle, in the cycle after the command. With bit 4 clear, no pulse is produced.
- R6: memRomSel is high only when memRd is high and either the address is in 0x0000-0x3FFF with lowerRomOn set, or the address is in 0xC000-0xFFFF with upperRomOn set. When memRd is low, memRomSel is low.
- R7: A byte whose bits 7:6 are 11 selects a RAM configuration from bits 2:0. The banks of quarters 0..3 for each configuration are:
  - 0: 0,1,2,3
  - 1: 0,1,2,7
  - 2: 4,5,6,7
  - 3: 0,3,2,7
  - 4: 0,4,2,3
  - 5: 0,5,2,3
  - 6: 0,6,2,3
  - 7: 0,7,2,3

  memBank gives the bank of the addressed quarter. memPhysAddr is {memBank, memAddr[13:0]}.
- R8: A RAM configuration command has no effect while ext128 is low.
- R9: For addresses in 0x4000-0xBFFF, memRomSel is always low.
- R10: cpuWait is low for one cycle and then high for three cycles, repeating. It is low in the first cycle after reset.
- R11: After reset, both ROM overlays are enabled, nextMode is 0, RAM configuration 0 is selected, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioStrobe | input | 1 | One-cycle marker of an I/O cycle, input or output |
| ioAddr | input | 16 | I/O address |
| ioData | input | 8 | Data bus value during the I/O cycle |
| ext128 | input | 1 | Enables RAM configuration commands |
| memAddr | input | 16 | CPU memory address |
| memRd | input | 1 | 1 for a read access, 0 for a write access |
| penStrobe | output | 1 | Pen select pulse |
| penIdx | output | 5 | Selected pen |
| inkStrobe | output | 1 | Colour write pulse |
| inkVal | output | 5 | Colour code |
| lowerRomOn | output | 1 | Low ROM overlay enabled |
| upperRomOn | output | 1 | High ROM overlay enabled |
| nextMode | output | 2 | Video mode for the next line |
| irqCountClr | output | 1 | Interrupt counter clear pulse |
| memRomSel | output | 1 | Current read is served by ROM |
| memBank | output | 3 | RAM bank of the addressed quarter |
| memPhysAddr | output | 17 | Physical RAM address |
| cpuWait | output | 1 | CPU wait request |

## Verification
The bench sweeps all eight RAM configurations and checks every quarter of each. A wrong entry in the irregular table, such as configuration 3 mapping quarter 1 to bank 1, would send CPU writes to the wrong bank.

It sends a configuration command with ext128 low and checks that the map stays put. It also sends a byte to an address outside the command port, where a sloppy decode would fire a spurious pen strobe.

It checks that ROM overlays reads but never writes. A design that routed writes through the overlay would drop stores to the top quarter.

It checks that the interrupt-counter clear fires only when bit 4 is set. It also checks the one-in-four phase of the wait line, since a design that gets this wrong would stall the CPU for the wrong number of cycles.

// File: rtl/gm_pkg.sv
package gm_pkg;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int BANK_W    = 3;
  localparam int OPND_W    = 5;
  localparam int QTR_W     = 2;
  localparam int NUM_QTR   = 1 << QTR_W;
  localparam int OFFS_W    = ADDR_W - QTR_W;
  localparam int PHYS_W    = BANK_W + OFFS_W;
  localparam int WAIT_PERIOD = 4;
  localparam int WAIT_W    = $clog2(WAIT_PERIOD);

  typedef enum logic [1:0] {
    FN_PEN  = 2'b00,
    FN_INK  = 2'b01,
    FN_CTRL = 2'b10,
    FN_RAM  = 2'b11
  } gaFn_e;

  typedef struct packed {
    logic              selPen;
    logic              setInk;
    logic              setCtrl;
    logic              setRam;
    logic [OPND_W-1:0] operand;
  } gaCmd_t;

  // bank backing quarter q under RAM configuration cfg
  function automatic logic [BANK_W-1:0] bankFor(input logic [2:0] cfg, input logic [1:0] q);
    logic [BANK_W-1:0] b;
    case (q)
      2'd0: b = (cfg == 3'd2) ? 3'd4 : 3'd0;
      2'd1: begin
        if (cfg[2])            b = {1'b1, cfg[1:0]};
        else if (cfg == 3'd2)  b = 3'd5;
        else if (cfg == 3'd3)  b = 3'd3;
        else                   b = 3'd1;
      end
      2'd2: b = (cfg == 3'd2) ? 3'd6 : 3'd2;
      default: b = (cfg == 3'd1 || cfg == 3'd2 || cfg == 3'd3) ? 3'd7 : 3'd3;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/gm_control.sv
module gm_control
  import gm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStrobe,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ext128,
  output gaCmd_t            cmd,
  output logic              cpuWait
);
  logic  portHit;
  gaFn_e fn;
  logic [WAIT_W-1:0] phase;

  // direction is not decoded: any I/O cycle at the port loads the byte
  assign portHit = ioStrobe && (ioAddr[ADDR_W-1 -: 2] == 2'b01);
  assign fn      = gaFn_e'(ioData[DATA_W-1 -: 2]);

  always_comb begin
    cmd         = '0;
    cmd.operand = ioData[OPND_W-1:0];
    if (portHit) begin
      case (fn)
        FN_PEN:  cmd.selPen  = 1'b1;
        FN_INK:  cmd.setInk  = 1'b1;
        FN_CTRL: cmd.setCtrl = 1'b1;
        default: cmd.setRam  = ext128;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else if (phase == WAIT_W'(WAIT_PERIOD - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign cpuWait = (phase != '0);
endmodule

// File: rtl/gm_datapath.sv
module gm_datapath
  import gm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  gaCmd_t            cmd,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memRd,
  output logic              penStrobe,
  output logic [OPND_W-1:0] penIdx,
  output logic              inkStrobe,
  output logic [OPND_W-1:0] inkVal,
  output logic              lowerRomOn,
  output logic              upperRomOn,
  output logic [1:0]        nextMode,
  output logic              irqCountClr,
  output logic              memRomSel,
  output logic [BANK_W-1:0] memBank,
  output logic [PHYS_W-1:0] memPhysAddr
);
  logic [2:0]        ramCfg;
  logic [BANK_W-1:0] qtrBank [NUM_QTR];
  logic [QTR_W-1:0]  qtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      penStrobe   <= 1'b0;
      penIdx      <= '0;
      inkStrobe   <= 1'b0;
      inkVal      <= '0;
      lowerRomOn  <= 1'b1;
      upperRomOn  <= 1'b1;
      nextMode    <= 2'd0;
      irqCountClr <= 1'b0;
      ramCfg      <= 3'd0;
    end else begin
      penStrobe   <= cmd.selPen;
      inkStrobe   <= cmd.setInk;
      irqCountClr <= cmd.setCtrl && cmd.operand[4];
      if (cmd.selPen) penIdx <= cmd.operand;
      if (cmd.setInk) inkVal <= cmd.operand;
      if (cmd.setCtrl) begin
        nextMode   <= cmd.operand[1:0];
        lowerRomOn <= !cmd.operand[2];
        upperRomOn <= !cmd.operand[3];
      end
      if (cmd.setRam) ramCfg <= cmd.operand[2:0];
    end
  end

  for (genvar q = 0; q < NUM_QTR; q++) begin : g_qtr
    assign qtrBank[q] = bankFor(ramCfg, QTR_W'(q));
  end

  assign qtr         = memAddr[ADDR_W-1 -: QTR_W];
  assign memBank     = qtrBank[qtr];
  assign memPhysAddr = {memBank, memAddr[OFFS_W-1:0]};
  assign memRomSel   = memRd && (((qtr == '0) && lowerRomOn) ||
                                 ((qtr == '1) && upperRomOn));
endmodule

// File: rtl/gate_mapper.sv
module gate_mapper
  import gm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioStrobe,
  input  logic [15:0]       ioAddr,
  input  logic [7:0]        ioData,
  input  logic              ext128,
  input  logic [15:0]       memAddr,
  input  logic              memRd,
  output logic              penStrobe,
  output logic [4:0]        penIdx,
  output logic              inkStrobe,
  output logic [4:0]        inkVal,
  output logic              lowerRomOn,
  output logic              upperRomOn,
  output logic [1:0]        nextMode,
  output logic              irqCountClr,
  output logic              memRomSel,
  output logic [2:0]        memBank,
  output logic [16:0]       memPhysAddr,
  output logic              cpuWait
);
  gaCmd_t cmd;

  gm_control u_ctrl (
    .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .ioAddr(ioAddr),
    .ioData(ioData), .ext128(ext128), .cmd(cmd), .cpuWait(cpuWait)
  );

  gm_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .memAddr(memAddr), .memRd(memRd),
    .penStrobe(penStrobe), .penIdx(penIdx), .inkStrobe(inkStrobe),
    .inkVal(inkVal), .lowerRomOn(lowerRomOn), .upperRomOn(upperRomOn),
    .nextMode(nextMode), .irqCountClr(irqCountClr), .memRomSel(memRomSel),
    .memBank(memBank), .memPhysAddr(memPhysAddr)
  );
endmodule

// File: rtl/gm_checker.sv
module gm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        ioStrobe,
  input logic [15:0] ioAddr,
  input logic [7:0]  ioData,
  input logic [15:0] memAddr,
  input logic        memRd,
  input logic        penStrobe,
  input logic        inkStrobe,
  input logic        lowerRomOn,
  input logic        irqCountClr,
  input logic        memRomSel,
  input logic        cpuWait
);
  AST_PEN_FROM_PORT: assert property (@(posedge clk) disable iff (!rstN)
    penStrobe |-> $past(ioStrobe && ioAddr[15:14] == 2'b01 && ioData[7:6] == 2'b00)); // R2
  AST_INK_FROM_PORT: assert property (@(posedge clk) disable iff (!rstN)
    inkStrobe |-> $past(ioStrobe && ioAddr[15:14] == 2'b01 && ioData[7:6] == 2'b01)); // R3
  AST_ROM_FLAG_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lowerRomOn) |-> $past(ioStrobe && ioAddr[15:14] == 2'b01 && ioData[7:6] == 2'b10)); // R4
  AST_IRQ_CLR_CMD: assert property (@(posedge clk) disable iff (!rstN)
    irqCountClr |-> $past(ioStrobe && ioAddr[15:14] == 2'b01 && ioData[7:6] == 2'b10 && ioData[4])); // R5
  AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    memRomSel |-> memRd); // R6
  AST_MID_RAM: assert property (@(posedge clk) disable iff (!rstN)
    (memAddr[15:14] == 2'b01 || memAddr[15:14] == 2'b10) |-> !memRomSel); // R9
  AST_WAIT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWait |=> cpuWait ##1 cpuWait ##1 cpuWait ##1 !cpuWait); // R10
endmodule

bind gate_mapper gm_checker u_chk (
  .clk(clk), .rstN(rstN), .ioStrobe(ioStrobe), .ioAddr(ioAddr),
  .ioData(ioData), .memAddr(memAddr), .memRd(memRd), .penStrobe(penStrobe),
  .inkStrobe(inkStrobe), .lowerRomOn(lowerRomOn), .irqCountClr(irqCountClr),
  .memRomSel(memRomSel), .cpuWait(cpuWait)
);

// File: tb/sim_gate_mapper.sv
`timescale 1ns/1ps
module sim_gate_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioStrobe = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioData = '0;
  logic        ext128 = 1'b0;
  logic [15:0] memAddr = '0;
  logic        memRd = 1'b1;
  logic        penStrobe, inkStrobe, lowerRomOn, upperRomOn, irqCountClr;
  logic        memRomSel, cpuWait;
  logic [4:0]  penIdx, inkVal;
  logic [1:0]  nextMode;
  logic [2:0]  memBank;
  logic [16:0] memPhysAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { int kind; logic [4:0] val; string req; } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  gate_mapper u0 (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] refBank(input int cfg, input int q);
    case (cfg)
      0: return 3'(q);
      1: return (q == 3) ? 3'd7 : 3'(q);
      2: return 3'(q + 4);
      3: return (q == 1) ? 3'd3 : ((q == 3) ? 3'd7 : 3'(q));
      default: return (q == 1) ? 3'(cfg) : 3'(q);
    endcase
  endfunction

  // driver: one I/O cycle, expected strobes pushed beforehand
  task automatic sendIo(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioData = d; ioStrobe = 1'b1;
    @(negedge clk);
    ioStrobe = 1'b0;
  endtask

  task automatic expectStrobe(input int kind, input logic [4:0] v, input string req);
    expItem_t it;
    it.kind = kind; it.val = v; it.req = req;
    expQ.push_back(it);
  endtask

  // monitor: 0 pen, 1 ink, 2 irq clear
  always @(negedge clk) begin
    if (rstN && !done) begin
      int kind;
      logic [4:0] v;
      kind = -1; v = '0;
      if (penStrobe)   begin kind = 0; v = penIdx; end
      if (inkStrobe)   begin kind = 1; v = inkVal; end
      if (irqCountClr) begin kind = 2; v = '0; end
      if (kind >= 0) begin
        if (expQ.size() == 0) check(1'b0, "R1 unexpected strobe", kind, -1);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          check(e.kind == kind && e.val == v, e.req, kind * 256 + int'(v), e.kind * 256 + int'(e.val));
        end
      end
    end
  end

  task automatic checkMap(input logic [15:0] a, input bit rd, input bit expRom,
                          input logic [2:0] expBank, input string req);
    @(negedge clk);
    memAddr = a; memRd = rd;
    #1;
    check(memRomSel == expRom, req, memRomSel, expRom);
    check(memBank == expBank && memPhysAddr == {expBank, a[13:0]}, req, memPhysAddr, {expBank, a[13:0]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(lowerRomOn && upperRomOn, "R11 roms", {lowerRomOn, upperRomOn}, 3);
    check(nextMode == 0, "R11 mode", nextMode, 0);
    check(!penStrobe && !inkStrobe && !irqCountClr, "R11 strobes", {penStrobe, inkStrobe, irqCountClr}, 0);
    checkMap(16'h4123, 1'b1, 1'b0, 3'd1, "R11 cfg0");

    // R10 wait pattern: one low in every four consecutive cycles
    begin
      int lows = 0;
      int lastLow = -1;
      bit spacingOk = 1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (!cpuWait) begin
          if (lastLow >= 0 && i - lastLow != 4) spacingOk = 0;
          lastLow = i; lows++;
        end
      end
      check(lows == 3 && spacingOk, "R10 wait", lows, 3);
    end

    // R2 pen select
    expectStrobe(0, 5'h05, "R2 pen");
    sendIo(16'h7F00, 8'h05);
    // R3 colour write
    expectStrobe(1, 5'h14, "R3 ink");
    sendIo(16'h7F00, 8'h54);
    // R1 wrong address: nothing expected
    sendIo(16'hBC00, 8'h03);
    sendIo(16'h0000, 8'h8C);
    @(negedge clk);
    check(lowerRomOn && upperRomOn, "R1 ignored address", {lowerRomOn, upperRomOn}, 3);
    // R1 other address in port range (input-style cycle)
    expectStrobe(0, 5'h1F, "R1 port range");
    sendIo(16'h4000, 8'h1F);

    // R4 ROMs off, mode 1
    sendIo(16'h7F00, 8'h8D);
    @(negedge clk);
    check(!lowerRomOn && !upperRomOn, "R4 roms off", {lowerRomOn, upperRomOn}, 0);
    check(nextMode == 2'd1, "R4 mode", nextMode, 1);
    checkMap(16'h0100, 1'b1, 1'b0, 3'd0, "R6 low rom off");
    checkMap(16'hC100, 1'b1, 1'b0, 3'd3, "R6 high rom off");

    // R5 irq clear with roms back on, mode 2
    expectStrobe(2, 5'h00, "R5 irq clear");
    sendIo(16'h7F00, 8'h92);
    @(negedge clk);
    check(lowerRomOn && upperRomOn && nextMode == 2, "R4 roms on", {lowerRomOn, upperRomOn, nextMode}, 'hE);
    checkMap(16'h0100, 1'b1, 1'b1, 3'd0, "R6 low rom read");
    checkMap(16'hC000, 1'b1, 1'b1, 3'd3, "R6 high rom read");
    checkMap(16'hC000, 1'b0, 1'b0, 3'd3, "R6 write to ram");
    checkMap(16'h0200, 1'b0, 1'b0, 3'd0, "R6 low write to ram");
    // R5 no pulse when bit4 clear
    sendIo(16'h7F00, 8'h83);
    @(negedge clk);
    check(nextMode == 3, "R5 no pulse mode", nextMode, 3);

    // R8 ignored without option
    ext128 = 1'b0;
    sendIo(16'h7F00, 8'hC2);
    checkMap(16'h4000, 1'b0, 1'b0, 3'd1, "R8 ignored q1");
    checkMap(16'h8000, 1'b0, 1'b0, 3'd2, "R8 ignored q2");

    // R7 and R9 full sweep
    ext128 = 1'b1;
    for (int c = 0; c < 8; c++) begin
      sendIo(16'h7F00, 8'hC0 | 8'(c));
      for (int q = 0; q < 4; q++) begin
        checkMap(16'(q * 16'h4000 + 16'h0ABC), 1'b0, 1'b0, refBank(c, q), "R7 bank");
      end
      checkMap(16'h4321, 1'b1, 1'b0, refBank(c, 1), "R9 mid read");
      checkMap(16'hBFFF, 1'b1, 1'b0, refBank(c, 2), "R9 mid read");
    end

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 missing strobes", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule